// File: doc/BRIEF.md
# I2C Byte-Register Slave

This block is an I2C target that holds a small bank of byte registers. A system clock oversamples the bus lines. Both SCL and SDA pass through a two-flop synchroniser, and the block finds bus conditions and clock edges from the synchronised copies. It answers one 7-bit device address, which is set by a parameter. It never drives SDA high: its only bus output is a pull-low request for an open-drain pad.

A write transaction has three parts: the address byte with the direction bit at 0, then one byte that loads an internal register pointer, then any number of data bytes. Each data byte lands at the pointer, and the pointer then steps forward by one. A read transaction sends the address byte with the direction bit at 1 and returns bytes starting at the current pointer. The pointer steps after every byte sent. The pointer keeps its value across START, repeated START and STOP, so a master can set it in a write and then turn the bus round with a repeated START to read. The block answers a pointer value beyond the register bank with NACK. It also answers a foreign device address with NACK. In both cases it stays silent until the next START or STOP.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset the block releases SDA (`sdaDriveLow` = 0), and every register reads back as 0x00.
- R2: When the address byte's upper seven bits, sent MSB first, equal `DEV_ADDR`, the block acknowledges it by pulling SDA low for the ninth clock. Bit 0 of the address byte selects the direction: 1 means read, 0 means write.
- R3: In a write, the byte after the address is acknowledged and loaded as the pointer when its value is below `MEM_DEPTH`.
- R4: Each later write byte is acknowledged and stored at the pointer, and the pointer then increments. For example, 0xA5 then 0x5A land in consecutive registers.
- R5: A read returns bytes MSB first, starting at the current pointer, and the pointer increments after each byte. The pointer keeps its value across repeated START and across STOP.
- R6: After the master NACKs a read byte, the block releases SDA and drives nothing more until a START or a STOP.
- R7: A pointer byte of `MEM_DEPTH` or more is answered with NACK. The block then ignores the rest of the transaction: it gives no ACK and alters no register.
- R8: An address byte whose upper seven bits differ from `DEV_ADDR` is answered with NACK. The block ignores the bus until the next START or STOP and alters no register.
- R9: After an access to register `MEM_DEPTH`-1, the pointer wraps to 0 for both reads and writes.
- R10: The block changes SDA only while SCL is low. The master samples SDA on the rising edge of SCL.
- R11: The block detects START as SDA falling while SCL is high, and STOP as SDA rising while SCL is high. A START from any state begins a new address phase. A STOP returns the block to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | SCL line as seen at the pad |
| sdaIn | input | 1 | SDA line as seen at the pad |
| sdaDriveLow | output | 1 | 1 pulls SDA low through the open-drain pad; 0 releases it |

## Verification
The hardest condition to reach from the ports is the pointer crossing the end of the register bank while it also survives a STOP. The stimulus writes two bytes starting at the last register. It then opens a fresh read without sending any pointer byte, so the first byte returned shows where the wrap left the pointer. A second read then reloads the pointer at the last register to show that both wrapped writes landed. The silent modes are checked the same way. After a refused pointer, a foreign address or a master NACK, the bench keeps clocking bytes and expects no ACK and an all-ones read. It then reads the bank back to confirm that nothing was written.

// File: rtl/i2c_reg_slave_pkg.sv
package i2c_reg_slave_pkg;

  // Strobes issued by the control unit to the datapath
  typedef struct packed {
    logic shiftIn;   // capture one received bit
    logic setPtr;    // load pointer from received byte
    logic writeMem;  // store received byte at pointer
    logic incPtr;    // advance pointer (wrapping)
    logic loadTx;    // load transmit shifter from pointer
    logic shiftTx;   // present next transmit bit
    logic ackDrive;  // pull SDA low for acknowledge
    logic txDrive;   // drive transmit shifter MSB
  } i2csStrobes_t;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_PTR, S_WDATA, S_ACK,
    S_RDATA, S_RACK, S_RNEXT, S_IGNORE
  } i2csState_t;

endpackage

// File: rtl/i2c_reg_slave_dpath.sv
module i2c_reg_slave_dpath
  import i2c_reg_slave_pkg::*;
#(
  parameter int MEM_DEPTH = 16,
  localparam int PTR_W = $clog2(MEM_DEPTH)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclIn,
  input  logic         sdaIn,
  input  i2csStrobes_t stb,
  output logic         sclRise,
  output logic         sclFall,
  output logic         startEv,
  output logic         stopEv,
  output logic         sdaBit,
  output logic [7:0]   rxByte,
  output logic         sdaDriveLow
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(MEM_DEPTH - 1);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclNow, sdaNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclNow  = sclSync[1];
  assign sdaNow  = sdaSync[1];
  assign sdaBit  = sdaNow;
  assign sclRise = sclNow & ~sclPrev;
  assign sclFall = ~sclNow & sclPrev;
  assign startEv = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopEv  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  logic [7:0]       rxShift, txShift;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       mem [MEM_DEPTH];

  assign rxByte = rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= 8'hFF;
      ptr     <= '0;
    end else begin
      if (stb.shiftIn) rxShift <= {rxShift[6:0], sdaNow};
      if (stb.loadTx)       txShift <= mem[ptr];
      else if (stb.shiftTx) txShift <= {txShift[6:0], 1'b1};
      if (stb.setPtr)      ptr <= rxShift[PTR_W-1:0];
      else if (stb.incPtr) ptr <= (ptr == LAST_PTR) ? '0 : ptr + 1'b1;
    end
  end

  for (genvar i = 0; i < MEM_DEPTH; i++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) mem[i] <= '0;
      else if (stb.writeMem && ptr == PTR_W'(i)) mem[i] <= rxShift;
    end
  end

  assign sdaDriveLow = stb.ackDrive | (stb.txDrive & ~txShift[7]);

endmodule

// File: rtl/i2c_reg_slave_ctrl.sv
module i2c_reg_slave_ctrl
  import i2c_reg_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h10,
  parameter int         MEM_DEPTH = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclRise,
  input  logic         sclFall,
  input  logic         startEv,
  input  logic         stopEv,
  input  logic         sdaBit,
  input  logic [7:0]   rxByte,
  output i2csStrobes_t stb
);

  i2csState_t state, ackNext;
  logic [3:0] bitCnt;
  logic       addrHit, ptrOk, recvState, byteDone;

  assign addrHit   = (rxByte[7:1] == DEV_ADDR);
  assign ptrOk     = (int'(rxByte) < MEM_DEPTH);
  assign recvState = (state == S_ADDR) || (state == S_PTR) || (state == S_WDATA);
  assign byteDone  = sclFall && (bitCnt == 4'd8);

  always_comb begin
    stb = '0;
    stb.ackDrive = (state == S_ACK);
    stb.txDrive  = (state == S_RDATA);
    if (!startEv && !stopEv) begin
      if (recvState) begin
        stb.shiftIn = sclRise && (bitCnt != 4'd8);
        if (byteDone && state == S_PTR)   stb.setPtr = ptrOk;
        if (byteDone && state == S_WDATA) begin
          stb.writeMem = 1'b1;
          stb.incPtr   = 1'b1;
        end
      end
      if (state == S_ACK && sclFall && ackNext == S_RDATA) stb.loadTx = 1'b1;
      if (state == S_RDATA && sclFall) begin
        stb.incPtr  = (bitCnt == 4'd7);
        stb.shiftTx = (bitCnt != 4'd7);
      end
      if (state == S_RNEXT && sclFall) stb.loadTx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      ackNext <= S_IDLE;
      bitCnt  <= '0;
    end else if (startEv) begin
      state  <= S_ADDR;
      bitCnt <= '0;
    end else if (stopEv) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_ADDR, S_PTR, S_WDATA: begin
          if (sclRise && bitCnt != 4'd8) bitCnt <= bitCnt + 4'd1;
          if (byteDone) begin
            bitCnt <= '0;
            if (state == S_ADDR) begin
              if (addrHit) begin
                state   <= S_ACK;
                ackNext <= rxByte[0] ? S_RDATA : S_PTR;
              end else state <= S_IGNORE;
            end else if (state == S_PTR && !ptrOk) begin
              state <= S_IGNORE;
            end else begin
              state   <= S_ACK;
              ackNext <= S_WDATA;
            end
          end
        end
        S_ACK: if (sclFall) begin
          state  <= ackNext;
          bitCnt <= '0;
        end
        S_RDATA: if (sclFall) begin
          if (bitCnt == 4'd7) state <= S_RACK;
          bitCnt <= bitCnt + 4'd1;
        end
        S_RACK: if (sclRise) state <= sdaBit ? S_IGNORE : S_RNEXT;
        S_RNEXT: if (sclFall) begin
          state  <= S_RDATA;
          bitCnt <= '0;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h10,
  parameter int         MEM_DEPTH = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaDriveLow
);

  i2csStrobes_t stb;
  logic       sclRise, sclFall, startEv, stopEv, sdaBit;
  logic [7:0] rxByte;

  i2c_reg_slave_ctrl #(.DEV_ADDR(DEV_ADDR), .MEM_DEPTH(MEM_DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .sdaBit(sdaBit),
    .rxByte(rxByte), .stb(stb)
  );

  i2c_reg_slave_dpath #(.MEM_DEPTH(MEM_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .sclRise(sclRise), .sclFall(sclFall), .startEv(startEv),
    .stopEv(stopEv), .sdaBit(sdaBit), .rxByte(rxByte),
    .sdaDriveLow(sdaDriveLow)
  );

endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int MEM_DEPTH = 16,
  localparam int PTR_W = $clog2(MEM_DEPTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclIn,
  input logic             sdaDriveLow,
  input logic             startEv,
  input logic             stopEv,
  input logic [PTR_W-1:0] ptr
);

  // R1: SDA released while reset is held
  a_r1_reset_release: assert property (@(posedge clk)
    !rstN |-> !sdaDriveLow);

  // R10: bus output only moves while SCL is low
  a_r10_sda_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> (!sclIn && !$past(sclIn)));

  // R11: a STOP leaves SDA released
  a_r11_stop_release: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !sdaDriveLow);

  // R11: a START opens an address phase with SDA released
  a_r11_start_release: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> !sdaDriveLow);

  // R4: the pointer only moves during an SCL low phase
  a_r4_ptr_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ptr) |-> !sclIn);

endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.MEM_DEPTH(MEM_DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDriveLow(sdaDriveLow),
  .startEv(uDp.startEv), .stopEv(uDp.stopEv), .ptr(uDp.ptr)
);

// File: tb/tb_i2c_reg_slave.sv
module tb_i2c_reg_slave;

  localparam logic [6:0] DEV = 7'h10;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaDriveLow;
  logic sdaBus;

  int nChecks = 0;
  int nFails  = 0;
  int highMoves = 0;
  int cycles = 0;
  logic prevDrive = 1'b0;

  always #4 clk = ~clk;

  assign sdaBus = sdaM & ~sdaDriveLow;

  i2c_reg_slave #(.DEV_ADDR(DEV), .MEM_DEPTH(16)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow)
  );

  // R10 monitor: count output moves seen while SCL is high
  always @(negedge clk) begin
    if (rstN && sdaDriveLow !== prevDrive && sclM) highMoves++;
    prevDrive <= sdaDriveLow;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles, expected below 150000", cycles);
      summary();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    if (!sclM) begin
      sdaM = 1'b1; waitQ();
      sclM = 1'b1; waitQ();
    end
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic clockBit(input logic b, output logic s);
    sdaM = b;    waitQ();
    sclM = 1'b1; waitQ();
    s = sdaBus;  waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    acked = !s;
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      b[i] = s;
    end
    clockBit(nack, s);
    sdaM = 1'b1;
  endtask

  // START, write address, pointer byte, both acknowledged
  task automatic aimPtr(input logic [7:0] p, input string req);
    logic a;
    busStart();
    sendByte({DEV, 1'b0}, a); check({req, " addr ack (R2)"}, a, 1);
    sendByte(p, a);           check({req, " ptr ack (R3)"}, a, 1);
  endtask

  task automatic readFrom(input logic [7:0] p, input int n,
                          input logic [7:0] e0, input logic [7:0] e1,
                          input logic [7:0] e2, input string req);
    logic a;
    logic [7:0] d;
    logic [7:0] e [3];
    e[0] = e0; e[1] = e1; e[2] = e2;
    aimPtr(p, req);
    busStart();
    sendByte({DEV, 1'b1}, a); check({req, " read addr ack after repeated START (R11)"}, a, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i == n - 1, d);
      check(req, d, e[i]);
    end
    busStop();
  endtask

  task automatic tReset();
    check("R1 sda released after reset", sdaDriveLow, 0);
    readFrom(8'h00, 3, 8'h00, 8'h00, 8'h00, "R1 reset contents");
  endtask

  task automatic tWrite();
    logic a;
    aimPtr(8'h01, "R4");
    sendByte(8'hA5, a); check("R4 data ack A5", a, 1);
    sendByte(8'h5A, a); check("R4 data ack 5A", a, 1);
    busStop();
    check("R11 released after STOP", sdaDriveLow, 0);
  endtask

  task automatic tRead();
    logic [7:0] d;
    readFrom(8'h01, 3, 8'hA5, 8'h5A, 8'h00, "R5 auto-increment read");
    // R6: NACKed read, then clock another byte: bus must stay high
    readFrom(8'h01, 1, 8'hA5, 8'h00, 8'h00, "R6 read before NACK");
    busStart();
    begin logic a; sendByte({DEV, 1'b1}, a); check("R6 addr ack", a, 1); end
    recvByte(1'b1, d);
    check("R6 byte before NACK", d, 8'h5A);
    recvByte(1'b1, d);
    check("R6 silent after master NACK", d, 8'hFF);
    busStop();
  endtask

  task automatic tBadPtr();
    logic a;
    busStart();
    sendByte({DEV, 1'b0}, a); check("R7 addr ack", a, 1);
    sendByte(8'h10, a);       check("R7 pointer 0x10 NACK", a, 0);
    sendByte(8'h77, a);       check("R7 following byte ignored", a, 0);
    busStop();
    readFrom(8'h01, 2, 8'hA5, 8'h5A, 8'h00, "R7 contents untouched");
    readFrom(8'h00, 1, 8'h00, 8'h00, 8'h00, "R7 reg0 untouched");
  endtask

  task automatic tWrongAddr();
    logic a;
    busStart();
    sendByte({7'h11, 1'b0}, a); check("R8 foreign address NACK", a, 0);
    sendByte(8'h01, a);         check("R8 pointer ignored", a, 0);
    sendByte(8'h99, a);         check("R8 data ignored", a, 0);
    busStop();
    readFrom(8'h01, 1, 8'hA5, 8'h00, 8'h00, "R8 contents untouched");
  endtask

  task automatic tWrap();
    logic a;
    logic [7:0] d;
    aimPtr(8'h0F, "R9");
    sendByte(8'h11, a); check("R9 ack at last reg", a, 1);
    sendByte(8'h22, a); check("R9 ack at wrapped reg", a, 1);
    busStop();
    // pointer now 1 after wrap; read without reloading it (R5 kept across STOP)
    busStart();
    sendByte({DEV, 1'b1}, a); check("R5 read addr ack", a, 1);
    recvByte(1'b1, d);
    check("R9 R5 pointer wrapped and kept across STOP", d, 8'hA5);
    busStop();
    readFrom(8'h0F, 3, 8'h11, 8'h22, 8'hA5, "R9 wrap on read");
  endtask

  task automatic tTiming();
    check("R10 sda moves while SCL high", highMoves, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    tReset();
    tWrite();
    tRead();
    tBadPtr();
    tWrongAddr();
    tWrap();
    tTiming();
    summary();
  end

endmodule